// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside an SDRAM controller and watches the command pins it drives, one sample per clock. Each cycle it turns the clock-enable, chip-select, row/column strobes, write-enable, A10 and bank-select levels into one command code. It keeps a small state machine per bank (idle, active, precharging) with down-counters that measure minimum command spacing in clocks. Every command that the addressed bank's state forbids, or that arrives before its spacing interval has run out, raises a one-cycle violation flag with a reason code and the bank at fault.

All nanosecond limits are parameters in picoseconds. They are turned into clock counts by rounding up against a clock-period parameter, so the same block serves any clock rate. A rejected command changes no state: the checker keeps tracking what the memory device would really be doing. Clock-enable transitions are decoded as low-power entry and exit events. What happens inside the device while it is in power-down or self-refresh is not modelled.

The block is a passive checker and never drives the memory bus. All of its outputs are registered. They reflect the command sampled at the previous rising edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high now and in the previous cycle, the command is decoded and cmd_o shows it on the cycle after sampling. cs_n high gives code 0 (deselect). With cs_n low, {ras_n,cas_n,we_n} gives: 111 = 1 (no-op), 110 = 2 (burst stop), 101 = read, 100 = write, 011 = 7 (activate), 010 = precharge, 001 = 10 (refresh) and 000 = 11 (mode register set).
- R2: A10 selects the variant. A read is code 3, or 4 with A10 high (auto-precharge). A write is code 5, or 6 with A10 high. A precharge is code 8 for the bank on ba_i with A10 low, or 9 for all banks with A10 high. Precharging a bank that is not active is legal and does nothing.
- R3: These raise a violation with no state change. A read or write to a bank that is not active gives reason 1. An activate to an active bank gives reason 2. An activate to a bank that is still precharging gives reason 9.
- R4: A read or write sooner than ceil(tRCD/period) clocks after its bank's activate gives reason 3 (5 clocks at the defaults). A precharge sooner than ceil(tRAS/period) clocks after the activate gives reason 4 (12 clocks).
- R5: An activate sooner than ceil(tRRD/period) clocks after the previous accepted activate gives reason 5 (3 clocks).
- R6: A precharge sooner than BURST_LEN-1+T_DPL_CLK clocks after a write to the same bank gives reason 6 (5 clocks at the defaults). Both single-bank and all-bank precharge are checked.
- R7: A precharged bank reads as precharging (code 2) and returns to idle (code 0) ceil(tRP/period) clocks after the precharge (5). A read with auto-precharge idles the bank BURST_LEN+tRP clocks after the read (9). A write with auto-precharge does so BURST_LEN-1+T_DPL_CLK+tRP clocks after the write (10).
- R8: Refresh, mode register set and self-refresh entry with any bank not idle give reason 7. After an accepted refresh, or an exit from self-refresh, any command other than deselect or no-op during the next ceil(tRC/period)-1 clocks gives reason 8 (14 clocks).
- R9: A violation sets viol_o for one cycle. It reports the reason on reason_o and the offending bank on viol_bank_o (the lowest failing bank for an all-bank precharge). Accepted commands report reason 0.
- R10: Clock enable falling (high last cycle, low now) gives code 13 (self-refresh entry) with a refresh pattern, else code 12 (power-down entry). Clock enable low in the previous cycle gives code 15 (held) while it stays low, or 14 (exit) when it rises. Pin levels in those cycles are not decoded as commands.
- R11: After reset all banks are idle, cmd_o is 0 and viol_o is low. bank_state_o carries two bits per bank, bank b at bits [2b+1:2b]: 0 idle, 1 active, 2 precharging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Sampled clock-enable pin |
| cs_ni | input | 1 | Sampled chip select, active low |
| ras_ni | input | 1 | Sampled row strobe, active low |
| cas_ni | input | 1 | Sampled column strobe, active low |
| we_ni | input | 1 | Sampled write enable, active low |
| a10_i | input | 1 | Sampled address bit 10 |
| ba_i | input | BA_W | Sampled bank select |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 2*NUM_BANKS | Per-bank state |
| viol_o | output | 1 | Violation pulse |
| reason_o | output | 4 | Violation reason code |
| viol_bank_o | output | BA_W | Bank that caused the violation |

## Verification
Every result (the command code, the violation flag, reason and bank, and the updated bank states) is due on the clock edge that samples the command. The bench sets the pins on the falling edge and reads the outputs one nanosecond after the next rising edge, so each check sees exactly the response to the command just issued. Spacing limits are tested at both sides of each boundary. The command one clock early must be rejected and the command at the limit accepted, with the intervening cycles filled by an exact number of no-ops.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESL    = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_BST     = 4'd2,
    CMD_RD      = 4'd3,
    CMD_RDA     = 4'd4,
    CMD_WR      = 4'd5,
    CMD_WRA     = 4'd6,
    CMD_ACT     = 4'd7,
    CMD_PRE     = 4'd8,
    CMD_PALL    = 4'd9,
    CMD_REF     = 4'd10,
    CMD_MRS     = 4'd11,
    CMD_PDN_IN  = 4'd12,
    CMD_SELF_IN = 4'd13,
    CMD_LP_EXIT = 4'd14,
    CMD_LP_HOLD = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECHG = 2'd2
  } bank_st_e;

  typedef enum logic [3:0] {
    RSN_NONE       = 4'd0,
    RSN_NOT_ACTIVE = 4'd1,
    RSN_NOT_IDLE   = 4'd2,
    RSN_TRCD       = 4'd3,
    RSN_TRAS       = 4'd4,
    RSN_TRRD       = 4'd5,
    RSN_TWR        = 4'd6,
    RSN_ALL_IDLE   = 4'd7,
    RSN_BUSY       = 4'd8,
    RSN_TRP        = 4'd9
  } reason_e;

  function automatic int unsigned ps_to_clk(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned load_of(input int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic a10_i,
  output cmd_e cmd_o
);

  cmd_e base;

  always_comb begin
    if (cs_ni) begin
      base = CMD_DESL;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  base = CMD_NOP;
        3'b110:  base = CMD_BST;
        3'b101:  base = a10_i ? CMD_RDA : CMD_RD;
        3'b100:  base = a10_i ? CMD_WRA : CMD_WR;
        3'b011:  base = CMD_ACT;
        3'b010:  base = a10_i ? CMD_PALL : CMD_PRE;
        3'b001:  base = CMD_REF;
        default: base = CMD_MRS;
      endcase
    end
  end

  always_comb begin
    if (!cke_prev_i)  cmd_o = cke_i ? CMD_LP_EXIT : CMD_LP_HOLD;
    else if (!cke_i)  cmd_o = (base == CMD_REF) ? CMD_SELF_IN : CMD_PDN_IN;
    else              cmd_o = base;
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int unsigned CW       = 6,
  parameter int unsigned RCD_CLK  = 5,
  parameter int unsigned RAS_CLK  = 12,
  parameter int unsigned RP_CLK   = 5,
  parameter int unsigned WR_HOLD  = 5,
  parameter int unsigned RDAP_CLK = 9,
  parameter int unsigned WRAP_CLK = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ap_i,
  input  logic     pre_i,
  output bank_st_e st_o,
  output logic     rcd_ok_o,
  output logic     ras_ok_o,
  output logic     wr_ok_o
);

  localparam logic [CW-1:0] RCD_LD = CW'(load_of(RCD_CLK));
  localparam logic [CW-1:0] RAS_LD = CW'(load_of(RAS_CLK));
  localparam logic [CW-1:0] WR_LD  = CW'(load_of(WR_HOLD));

  bank_st_e      st_q;
  logic [CW-1:0] rcd_q, ras_q, wr_q, rp_q;
  logic [CW-1:0] close_len;
  logic          close_go;

  assign close_go  = pre_i || ((rd_i || wr_i) && ap_i);
  assign close_len = pre_i ? CW'(RP_CLK) : (wr_i ? CW'(WRAP_CLK) : CW'(RDAP_CLK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      rcd_q <= '0;
      ras_q <= '0;
      wr_q  <= '0;
      rp_q  <= '0;
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (wr_q  != '0) wr_q  <= wr_q  - 1'b1;
      if (st_q == BK_PRECHG) begin
        if (rp_q <= CW'(1)) begin
          st_q <= BK_IDLE;
          rp_q <= '0;
        end else begin
          rp_q <= rp_q - 1'b1;
        end
      end
      if (act_i) begin
        st_q  <= BK_ACTIVE;
        rcd_q <= RCD_LD;
        ras_q <= RAS_LD;
        wr_q  <= '0;
      end
      if (wr_i) wr_q <= WR_LD;
      if (close_go) begin
        if (close_len <= CW'(1)) begin
          st_q <= BK_IDLE;
          rp_q <= '0;
        end else begin
          st_q <= BK_PRECHG;
          rp_q <= close_len - 1'b1;
        end
      end
    end
  end

  assign st_o     = st_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign ras_ok_o = (ras_q == '0);
  assign wr_ok_o  = (wr_q == '0);

  assert_state_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != 2'd3);
  assert_col_needs_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |-> (st_q == BK_ACTIVE));
  assert_col_after_rcd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |-> (rcd_q == '0));
  assert_pre_after_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (ras_q == '0));
  assert_pre_after_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (wr_q == '0));
  assert_act_needs_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (st_q == BK_ACTIVE));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_RCD_PS  = 18000,
  parameter int unsigned T_RAS_PS  = 48000,
  parameter int unsigned T_RP_PS   = 18000,
  parameter int unsigned T_RC_PS   = 60000,
  parameter int unsigned T_RRD_PS  = 12000,
  parameter int unsigned T_DPL_CLK = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic                   a10_i,
  input  logic [BA_W-1:0]        ba_i,
  output logic [3:0]             cmd_o,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic                   viol_o,
  output logic [3:0]             reason_o,
  output logic [BA_W-1:0]        viol_bank_o
);

  localparam int unsigned RCD_CLK  = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int unsigned RAS_CLK  = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int unsigned RP_CLK   = ps_to_clk(T_RP_PS, CLK_PS);
  localparam int unsigned RC_CLK   = ps_to_clk(T_RC_PS, CLK_PS);
  localparam int unsigned RRD_CLK  = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int unsigned WR_HOLD  = BURST_LEN - 1 + T_DPL_CLK;
  localparam int unsigned RDAP_CLK = BURST_LEN + RP_CLK;
  localparam int unsigned WRAP_CLK = WR_HOLD + RP_CLK;
  localparam int unsigned CW       = $clog2(RC_CLK + RAS_CLK + RRD_CLK + WRAP_CLK + 2);
  localparam logic [CW-1:0] RRD_LD = CW'(load_of(RRD_CLK));
  localparam logic [CW-1:0] RC_LD  = CW'(load_of(RC_CLK));

  cmd_e     cmd;
  logic     cke_q, in_self_q;
  logic [CW-1:0] rrd_q, rc_q;

  bank_st_e st [NUM_BANKS];
  logic [NUM_BANKS-1:0] rcd_ok, ras_ok, wr_ok;
  logic [NUM_BANKS-1:0] op_act, op_rd, op_wr, op_pre;
  logic     op_ap, all_idle, busy, viol, self_go;
  reason_e  rsn;
  logic [BA_W-1:0] vbank;

  cmd_e            cmd_q;
  logic            viol_q;
  reason_e         rsn_q;
  logic [BA_W-1:0] vbank_q;

  sdram_cmd_decode u_decode (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .a10_i      (a10_i),
    .cmd_o      (cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_track #(
      .CW       (CW),
      .RCD_CLK  (RCD_CLK),
      .RAS_CLK  (RAS_CLK),
      .RP_CLK   (RP_CLK),
      .WR_HOLD  (WR_HOLD),
      .RDAP_CLK (RDAP_CLK),
      .WRAP_CLK (WRAP_CLK)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (op_act[b]),
      .rd_i     (op_rd[b]),
      .wr_i     (op_wr[b]),
      .ap_i     (op_ap),
      .pre_i    (op_pre[b]),
      .st_o     (st[b]),
      .rcd_ok_o (rcd_ok[b]),
      .ras_ok_o (ras_ok[b]),
      .wr_ok_o  (wr_ok[b])
    );
    assign bank_state_o[2*b +: 2] = st[b];
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st[b] != BK_IDLE) all_idle = 1'b0;
    end
  end

  assign busy = (rc_q != '0);

  // legality: at most one reason per cycle, no bank op on violation
  always_comb begin
    viol    = 1'b0;
    rsn     = RSN_NONE;
    vbank   = ba_i;
    op_act  = '0;
    op_rd   = '0;
    op_wr   = '0;
    op_pre  = '0;
    op_ap   = 1'b0;
    self_go = 1'b0;
    if (busy && !(cmd inside {CMD_DESL, CMD_NOP, CMD_LP_HOLD, CMD_LP_EXIT})) begin
      viol = 1'b1;
      rsn  = RSN_BUSY;
    end else begin
      case (cmd)
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
          if (st[ba_i] != BK_ACTIVE) begin
            viol = 1'b1;
            rsn  = RSN_NOT_ACTIVE;
          end else if (!rcd_ok[ba_i]) begin
            viol = 1'b1;
            rsn  = RSN_TRCD;
          end else begin
            op_ap = (cmd == CMD_RDA) || (cmd == CMD_WRA);
            if (cmd == CMD_RD || cmd == CMD_RDA) op_rd[ba_i] = 1'b1;
            else                                 op_wr[ba_i] = 1'b1;
          end
        end
        CMD_ACT: begin
          if (st[ba_i] == BK_PRECHG) begin
            viol = 1'b1;
            rsn  = RSN_TRP;
          end else if (st[ba_i] == BK_ACTIVE) begin
            viol = 1'b1;
            rsn  = RSN_NOT_IDLE;
          end else if (rrd_q != '0) begin
            viol = 1'b1;
            rsn  = RSN_TRRD;
          end else begin
            op_act[ba_i] = 1'b1;
          end
        end
        CMD_PRE: begin
          if (st[ba_i] == BK_ACTIVE) begin
            if (!ras_ok[ba_i]) begin
              viol = 1'b1;
              rsn  = RSN_TRAS;
            end else if (!wr_ok[ba_i]) begin
              viol = 1'b1;
              rsn  = RSN_TWR;
            end else begin
              op_pre[ba_i] = 1'b1;
            end
          end
        end
        CMD_PALL: begin
          // descending scan so the lowest failing bank is reported
          for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (st[b] == BK_ACTIVE && (!ras_ok[b] || !wr_ok[b])) begin
              viol  = 1'b1;
              rsn   = !ras_ok[b] ? RSN_TRAS : RSN_TWR;
              vbank = BA_W'(b);
            end
          end
          if (!viol) begin
            for (int b = 0; b < NUM_BANKS; b++) op_pre[b] = (st[b] == BK_ACTIVE);
          end
        end
        CMD_REF, CMD_MRS, CMD_SELF_IN: begin
          if (!all_idle) begin
            viol = 1'b1;
            rsn  = RSN_ALL_IDLE;
          end else if (cmd == CMD_SELF_IN) begin
            self_go = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q     <= 1'b1;
      in_self_q <= 1'b0;
      rrd_q     <= '0;
      rc_q      <= '0;
    end else begin
      cke_q <= cke_i;
      if (|op_act)             rrd_q <= RRD_LD;
      else if (rrd_q != '0)    rrd_q <= rrd_q - 1'b1;
      if (cmd == CMD_REF && !viol)                rc_q <= RC_LD;
      else if (cmd == CMD_LP_EXIT && in_self_q)   rc_q <= RC_LD;
      else if (rc_q != '0)                        rc_q <= rc_q - 1'b1;
      if (self_go)                   in_self_q <= 1'b1;
      else if (cmd == CMD_LP_EXIT)   in_self_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_DESL;
      viol_q  <= 1'b0;
      rsn_q   <= RSN_NONE;
      vbank_q <= '0;
    end else begin
      cmd_q   <= cmd;
      viol_q  <= viol;
      rsn_q   <= rsn;
      vbank_q <= viol ? vbank : '0;
    end
  end

  assign cmd_o       = cmd_q;
  assign viol_o      = viol_q;
  assign reason_o    = rsn_q;
  assign viol_bank_o = vbank_q;

  assert_reason_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (reason_o != 4'd0));
  assert_reason_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_o |-> (reason_o == 4'd0));
  assert_ref_all_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && !viol_o) |-> (bank_state_o == '0));
  assert_lp_hold_after_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_LP_HOLD) |-> $past(cmd_o) inside {CMD_PDN_IN, CMD_SELF_IN, CMD_LP_HOLD});

  if (RRD_CLK >= 2) begin : g_rrd_chk
    assert_act_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_ACT && !viol_o) |=> !(cmd_o == CMD_ACT && !viol_o));
  end

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;

  localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_RDA = 4, C_WR = 5,
                 C_WRA = 6, C_ACT = 7, C_PRE = 8, C_PALL = 9, C_REF = 10, C_MRS = 11,
                 C_PDN = 12, C_SELF = 13, C_EXIT = 14, C_HOLD = 15;
  localparam int S_IDLE = 0, S_ACT = 1, S_PRE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [3:0] cmd_o, reason_o;
  logic [7:0] bank_state_o;
  logic       viol_o;
  logic [1:0] viol_bank_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .a10_i(a10), .ba_i(ba),
    .cmd_o(cmd_o), .bank_state_o(bank_state_o), .viol_o(viol_o),
    .reason_o(reason_o), .viol_bank_o(viol_bank_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic r, input logic s,
                       input logic w, input logic a, input logic [1:0] b);
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; a10 = a; ba = b;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();            drive(1, 0, 1, 1, 1, 0, 0); endtask
  task automatic desl();           drive(1, 1, 0, 0, 0, 0, 0); endtask
  task automatic bst();            drive(1, 0, 1, 1, 0, 0, 0); endtask
  task automatic act(input int b); drive(1, 0, 0, 1, 1, 0, 2'(b)); endtask
  task automatic rd(input int b, input logic ap); drive(1, 0, 1, 0, 1, ap, 2'(b)); endtask
  task automatic wr(input int b, input logic ap); drive(1, 0, 1, 0, 0, ap, 2'(b)); endtask
  task automatic pre(input int b); drive(1, 0, 0, 1, 0, 0, 2'(b)); endtask
  task automatic pall();           drive(1, 0, 0, 1, 0, 1, 0); endtask
  task automatic refr();           drive(1, 0, 0, 0, 1, 0, 0); endtask
  task automatic mrs();            drive(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nop();
  endtask

  task automatic expect_out(input string req, input int c, input int v, input int r);
    check({req, " cmd"}, cmd_o, c);
    check({req, " viol"}, viol_o, v);
    check({req, " reason"}, reason_o, r);
  endtask

  task automatic expect_bank(input string req, input int b, input int s);
    check({req, " bank state"}, bank_state_o[2*b +: 2], s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; a10 = 0; ba = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R11 reset states", bank_state_o, 0);
    check("R11 reset cmd", cmd_o, C_DESL);
    check("R11 reset viol", viol_o, 0);
  endtask

  task automatic t_decode();
    do_reset();
    refr();    expect_out("R1 refresh", C_REF, 0, 0);
    idle(14);
    mrs();     expect_out("R1 mode set", C_MRS, 0, 0);
    desl();    expect_out("R1 deselect", C_DESL, 0, 0);
    nop();     expect_out("R1 nop", C_NOP, 0, 0);
    bst();     expect_out("R1 burst stop", C_BST, 0, 0);
    pre(2);    expect_out("R2 precharge idle bank", C_PRE, 0, 0);
    expect_bank("R2 precharge idle no effect", 2, S_IDLE);
    pall();    expect_out("R2 precharge all", C_PALL, 0, 0);
    act(1);    expect_out("R1 activate", C_ACT, 0, 0);
    expect_bank("R11 active code", 1, S_ACT);
    idle(4);
    rd(1, 0);  expect_out("R1 read", C_RD, 0, 0);
    wr(1, 0);  expect_out("R1 write", C_WR, 0, 0);
    rd(1, 1);  expect_out("R2 read autoprecharge", C_RDA, 0, 0);
    expect_bank("R2 autoprecharge starts", 1, S_PRE);
  endtask

  task automatic t_state_rules();
    do_reset();
    rd(0, 0);  expect_out("R3 read idle bank", C_RD, 1, 1);
    check("R9 offending bank", viol_bank_o, 0);
    expect_bank("R9 state kept", 0, S_IDLE);
    wr(3, 0);  expect_out("R3 write idle bank", C_WR, 1, 1);
    check("R9 offending bank 3", viol_bank_o, 3);
    act(2);    expect_out("R3 first act", C_ACT, 0, 0);
    act(2);    expect_out("R3 act active bank", C_ACT, 1, 2);
    check("R9 bank of double act", viol_bank_o, 2);
    expect_bank("R9 state kept active", 2, S_ACT);
    idle(10);
    pre(2);    expect_out("R4 precharge at tRAS", C_PRE, 0, 0);
    act(2);    expect_out("R3 act precharging bank", C_ACT, 1, 9);
    expect_bank("R7 still precharging", 2, S_PRE);
  endtask

  task automatic t_timing();
    do_reset();
    act(0);
    rd(0, 0);  expect_out("R4 read before tRCD", C_RD, 1, 3);
    act(1);    expect_out("R5 act before tRRD", C_ACT, 1, 5);
    check("R5 bank", viol_bank_o, 1);
    expect_bank("R9 bank1 unchanged", 1, S_IDLE);
    act(1);    expect_out("R5 act at tRRD", C_ACT, 0, 0);
    pre(0);    expect_out("R4 precharge before tRAS", C_PRE, 1, 4);
    expect_bank("R9 bank0 kept", 0, S_ACT);
    do_reset();
    act(0);
    idle(3);
    rd(0, 0);  expect_out("R4 read one early", C_RD, 1, 3);
    rd(0, 0);  expect_out("R4 read at tRCD", C_RD, 0, 0);
  endtask

  task automatic t_write_recovery();
    do_reset();
    act(3);
    idle(7);
    wr(3, 0);  expect_out("R6 write", C_WR, 0, 0);
    idle(3);
    pre(3);    expect_out("R6 precharge in recovery", C_PRE, 1, 6);
    check("R6 bank", viol_bank_o, 3);
    expect_bank("R6 state kept", 3, S_ACT);
    pre(3);    expect_out("R6 precharge after recovery", C_PRE, 0, 0);
    expect_bank("R7 precharging", 3, S_PRE);
    idle(3);
    act(3);    expect_out("R7 act one before tRP", C_ACT, 1, 9);
    act(3);    expect_out("R7 act at tRP", C_ACT, 0, 0);
  endtask

  task automatic t_autoprecharge();
    do_reset();
    act(0);
    idle(4);
    rd(0, 1);
    idle(7);
    act(0);    expect_out("R7 read ap one early", C_ACT, 1, 9);
    act(0);    expect_out("R7 read ap idle", C_ACT, 0, 0);
    do_reset();
    act(0);
    idle(4);
    wr(0, 1);  expect_out("R2 write ap", C_WRA, 0, 0);
    idle(8);
    act(0);    expect_out("R7 write ap one early", C_ACT, 1, 9);
    act(0);    expect_out("R7 write ap idle", C_ACT, 0, 0);
  endtask

  task automatic t_pall();
    do_reset();
    act(0);
    idle(2);
    act(1);
    idle(8);
    pall();    expect_out("R4 precharge all early", C_PALL, 1, 4);
    check("R9 lowest failing bank", viol_bank_o, 1);
    check("R9 states kept", bank_state_o, 8'b0000_0101);
    idle(2);
    pall();    expect_out("R2 precharge all ok", C_PALL, 0, 0);
    check("R7 both precharging", bank_state_o, 8'b0000_1010);
  endtask

  task automatic t_refresh();
    do_reset();
    act(0);
    refr();    expect_out("R8 refresh with open bank", C_REF, 1, 7);
    mrs();     expect_out("R8 mode set with open bank", C_MRS, 1, 7);
    expect_bank("R8 bank kept", 0, S_ACT);
    do_reset();
    refr();
    idle(13);
    act(0);    expect_out("R8 act while busy", C_ACT, 1, 8);
    act(0);    expect_out("R8 act after tRC", C_ACT, 0, 0);
  endtask

  task automatic t_lowpower();
    do_reset();
    drive(0, 0, 1, 1, 1, 0, 0);  expect_out("R10 power-down entry", C_PDN, 0, 0);
    drive(0, 0, 0, 1, 1, 0, 0);  expect_out("R10 held not decoded", C_HOLD, 0, 0);
    expect_bank("R10 act ignored while low", 0, S_IDLE);
    drive(1, 0, 0, 1, 1, 0, 0);  expect_out("R10 exit", C_EXIT, 0, 0);
    expect_bank("R10 exit not decoded", 0, S_IDLE);
    act(0);    expect_out("R10 act after power-down", C_ACT, 0, 0);
    do_reset();
    drive(0, 0, 0, 0, 1, 0, 0);  expect_out("R10 self entry", C_SELF, 0, 0);
    drive(0, 1, 1, 1, 1, 0, 0);  expect_out("R10 self held", C_HOLD, 0, 0);
    drive(1, 1, 1, 1, 1, 0, 0);  expect_out("R10 self exit", C_EXIT, 0, 0);
    act(0);    expect_out("R8 busy after self exit", C_ACT, 1, 8);
    do_reset();
    act(0);
    drive(0, 0, 0, 0, 1, 0, 0);  expect_out("R8 self entry with open bank", C_SELF, 1, 7);
    drive(1, 1, 1, 1, 1, 0, 0);
    act(1);    expect_out("R10 no busy after refused entry", C_ACT, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_state_rules();
    t_timing();
    t_write_recovery();
    t_autoprecharge();
    t_pall();
    t_refresh();
    t_lowpower();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule